// File: doc/BRIEF.md
# Square-Wave Clock Divider

This block turns a fast system clock into a slow square wave of exactly half duty, together with a one-cycle strobe that marks each half-period boundary. With the default parameters it takes a 50 MHz clock and produces 1 kHz. A modulo counter runs from zero up to one less than the half-period length, then wraps. On the cycle where the counter holds its last value, a combinational wrap strobe is raised. That strobe drives a two-state phase machine, which flips the square-wave level at the same clock edge on which the counter returns to zero.

Every register, the phase machine included, is clocked by the one system clock. Downstream logic should use the square wave as a level or a clock enable, and the strobe as a single-cycle enable, but never as a clock. Logic that runs from these outputs should have its own reset, not the divider's. The phase machine has two states. `PH_LOW` drives the output low and `PH_HIGH` drives it high. The transition `PH_LOW -> PH_HIGH` is taken on a wrap in the low phase. The transition `PH_HIGH -> PH_LOW` is taken on a wrap in the high phase. With no wrap, each state holds itself. Reset forces `PH_LOW` from either state.

Top module: `sq_wave_divider`

## Requirements
- R1: Reset is synchronous and active high. At a clock edge that samples `reset` high, the counter becomes 0 and the phase machine enters `PH_LOW`. After that edge, `sq_out` and `wrap_tick` both read 0.
- R2: The half-period length is CLK_HZ / (2 * OUT_HZ), which is 25000 by default. While reset is low, the counter goes up by one at every edge through 0..24999 and returns to 0 after 24999. So wraps occur 25000 edges apart.
- R3: `wrap_tick` is a combinational decode of the counter. It is 1 exactly while the counter holds 24999. Counting edges from the release of reset, it is high after edges 24999, 49999, 74999 and so on. It is never high for two cycles in a row.
- R4: `sq_out` is 1 in `PH_HIGH` and 0 in `PH_LOW`. It inverts at every edge where `wrap_tick` is 1 and holds at all other edges. After edge k following reset release, `sq_out` equals (k / 25000) mod 2.
- R5: Once the first wrap has passed, every high interval of `sq_out` lasts exactly 25000 cycles. One full output period is therefore 50000 input cycles, at 50% duty.
- R6: If reset is asserted while `sq_out` is high, the output goes low at the next edge and the whole schedule starts again from edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock used by the block |
| reset | input | 1 | Synchronous active-high reset of counter and phase machine |
| sq_out | output | 1 | Divided square wave, 50% duty, registered |
| wrap_tick | output | 1 | One-cycle strobe while the counter holds its last value |

## Verification
The properties assume that `reset` changes only away from the active clock edge and holds a known level from the very first edge. Under that assumption every clocked check can treat a reset edge as a boundary that aborts any property in progress. The stimulus keeps to this assumption. It holds reset high from time zero and moves it only one nanosecond after a rising edge. The single mid-run reset falls inside a high phase of the output, so the abort path of the toggle and hold properties is exercised along with the R6 restart.

// File: rtl/sq_wave_divider_pkg.sv
package sq_wave_divider_pkg;

    // Phase of the divided square wave; the encoding is the output level.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/mod_counter.sv
module mod_counter #(
    parameter int MOD = 25000,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         reset,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         carry
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_q;

    // Carry is decoded from the register directly, so it is
    // valid in the same cycle as the terminal value.
    always_comb begin
        carry = en && (count_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (reset) begin
            count_q <= '0;
        end else if (en) begin
            if (carry) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + ONE;
            end
        end
    end

    assign count = count_q;

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import sq_wave_divider_pkg::*;
(
    input  logic clk,
    input  logic reset,
    input  logic flip,
    output logic level
);

    phase_e state_q;
    phase_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (flip) state_d = PH_HIGH;
            PH_HIGH: if (flip) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (reset) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            PH_HIGH: level = 1'b1;
            PH_LOW:  level = 1'b0;
            default: level = 1'b0;
        endcase
    end

endmodule

// File: rtl/sq_wave_divider.sv
module sq_wave_divider #(
    parameter int CLK_HZ = 50_000_000,
    parameter int OUT_HZ = 1000
) (
    input  logic clk,
    input  logic reset,
    output logic sq_out,
    output logic wrap_tick
);

    localparam int HALF_DIV = CLK_HZ / (2 * OUT_HZ);
    localparam int CNT_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] count_q;
    logic             carry;

    mod_counter #(
        .MOD (HALF_DIV),
        .W   (CNT_W)
    ) u_count (
        .clk   (clk),
        .reset (reset),
        .en    (1'b1),
        .count (count_q),
        .carry (carry)
    );

    phase_fsm u_phase (
        .clk   (clk),
        .reset (reset),
        .flip  (carry),
        .level (sq_out)
    );

    assign wrap_tick = carry;

endmodule

// File: rtl/sq_wave_divider_checks.sv
module sq_wave_divider_checks #(
    parameter int MOD = 25000,
    parameter int W   = $clog2(MOD)
) (
    input logic         clk,
    input logic         reset,
    input logic         sq_out,
    input logic         wrap_tick,
    input logic [W-1:0] count
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        reset |=> (!sq_out && !wrap_tick && count == '0)); // R1

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (reset)
        (32'(count) < MOD)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (reset)
        !wrap_tick |=> (count == $past(count) + W'(1))); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (reset)
        wrap_tick |=> (count == '0)); // R2

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (reset)
        wrap_tick |=> !wrap_tick); // R3

    AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (reset)
        wrap_tick |=> (sq_out != $past(sq_out))); // R4

    AST_HOLD_OFF_WRAP: assert property (@(posedge clk) disable iff (reset)
        !wrap_tick |=> $stable(sq_out)); // R4

endmodule

bind sq_wave_divider sq_wave_divider_checks #(
    .MOD (HALF_DIV),
    .W   (CNT_W)
) u_checks (
    .clk       (clk),
    .reset     (reset),
    .sq_out    (sq_out),
    .wrap_tick (wrap_tick),
    .count     (count_q)
);

// File: tb/sq_wave_divider_test.sv
`timescale 1ns/1ps
module sq_wave_divider_test;

    localparam int HALF = 25000;

    logic clk   = 1'b0;
    logic reset = 1'b1;
    logic sq_out;
    logic wrap_tick;

    always #2.5 clk = ~clk;

    sq_wave_divider uut (
        .clk       (clk),
        .reset     (reset),
        .sq_out    (sq_out),
        .wrap_tick (wrap_tick)
    );

    int   n_cmp    = 0;
    int   n_bad    = 0;
    int   exp_q[$];
    int   n        = 0;
    int   high_run = 0;
    logic rst_seen = 1'b1;
    logic started  = 1'b0;
    logic prev_sq  = 1'b0;
    logic done     = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver side of the scoreboard: expected tick positions
    task automatic push_ticks(input int k);
        for (int i = 1; i <= k; i++) exp_q.push_back(i * HALF - 1);
    endtask

    always @(posedge clk) begin
        rst_seen <= reset;
        started  <= 1'b1;
    end

    // Monitor side: compares every cycle away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            if (rst_seen) begin
                n = 0;
                check("R1 sq_out after reset edge", 32'(sq_out), 0);
                check("R1 wrap_tick after reset edge", 32'(wrap_tick), 0);
                high_run = 0;
                prev_sq  = 1'b0;
            end else begin
                n++;
                check("R3 wrap_tick level", 32'(wrap_tick), 32'((n % HALF) == HALF - 1));
                check("R4 sq_out level", 32'(sq_out), 32'((n / HALF) % 2));
                if (wrap_tick === 1'b1) begin
                    if (exp_q.size() == 0) begin
                        check("R2 unexpected tick", 32'(n), 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check("R2 tick position", 32'(n), 32'(e));
                    end
                end
                if (sq_out === 1'b1) high_run++;
                if (prev_sq && sq_out === 1'b0) begin
                    check("R5 high interval length", 32'(high_run), HALF);
                    high_run = 0;
                end
                prev_sq = sq_out;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state sq_out", 32'(sq_out), 0);
        check("R1 reset state wrap_tick", 32'(wrap_tick), 0);
        push_ticks(1);
        reset = 1'b0;
        repeat (30000) @(posedge clk);
        #1;
        check("R6 sq_out high before mid-run reset", 32'(sq_out), 1);
        reset = 1'b1;
        @(posedge clk);
        #1;
        check("R6 sq_out cleared by mid-run reset", 32'(sq_out), 0);
        check("R6 wrap_tick cleared by mid-run reset", 32'(wrap_tick), 0);
        check("R2 all ticks before reset seen", 32'(exp_q.size()), 0);
        exp_q.delete();
        push_ticks(4);
        reset = 1'b0;
        repeat (110000) @(posedge clk);
        #1;
        check("R3 all expected ticks observed", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule